// File: doc/BRIEF.md
# Debug Memory Access Command Engine

This block sits behind the bit-level shifter of a serial debug port. It consumes one 16-bit word per exchange slot and presents a 17-bit response word (a status bit above 16 data bits) that the host collects in the same slot. The slot-by-slot word stream becomes memory reads, memory writes and block dumps on a simple request/acknowledge bus master. Addresses and longword data arrive as two 16-bit halves and are assembled inside the engine. Byte, word and longword accesses drive the correct byte lanes of the 32-bit bus.

A command word carries the operation and the access size. Read and write commands are followed by the address halves, and a write then takes its data words. While operands are outstanding or the bus access is pending, every slot answers with a not-ready code. The result or completion code comes out in the first slot after the access ends. The word received in that slot is already taken as the next command. A dump command needs no operands: it steps the address left by the previous read or dump by the operand size and fetches the next item, so large blocks can be read one slot per item.

Top module: `dbg_mem_cmd_engine`

## Requirements
- R1: After reset the response word is 0x1_0000 (not ready) and no bus request is active.
- R2: A command word holds the operation in bits 15:12 (0x1 read, 0x2 write, 0x3 dump) and the size in bits 1:0 (0 byte, 1 word, 2 longword). Any other operation code, or size 3, makes the next slot return 0x1_FFFF. No bus access starts, and the word after it is decoded as a fresh command.
- R3: The address follows a read or write command as two words, bits 31:16 first and then bits 15:0, and appears unchanged on `bus_addr`.
- R4: Write data follows the address. A byte write takes one word whose bits 7:0 are the byte and whose bits 15:8 are ignored. A word write takes one word, and a longword write takes two words with bits 31:16 first. Byte enables are one-hot at lane addr[1:0] for a byte, lanes 1:0 or 3:2 (chosen by addr[1]) for a word, and all four lanes for a longword. Lane n carries bits 8n+7:8n.
- R5: A write that ends with acknowledge makes the next slot return 0x0_FFFF.
- R6: An access that ends with bus error makes the next slot return 0x1_0001. It also breaks the read chain required by R10.
- R7: Every slot taken while operands are being collected or while the bus access is pending returns 0x1_0000. Words received during a pending access are dropped.
- R8: A read returns status 0 with data from the addressed lane. A byte is zero-extended in bits 7:0 and a word sits in bits 15:0. A longword takes two slots, bits 31:16 first, and the word received in the first of those slots is ignored.
- R9: A dump first adds 1, 2 or 4 (its own size) to the address of the previous read or dump, then reads that address and returns the item as in R8. Repeated dumps walk through memory.
- R10: A dump is accepted only when the last completed command was a successful read or dump. Otherwise it is illegal as in R2 and starts no bus access.
- R11: Once raised, the request holds address, size, write enable, byte enables and write data stable until acknowledge or bus error, and drops in the cycle after.
- R12: The word received in the slot that returns a result or completion code is decoded as the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_valid | input | 1 | One-cycle pulse marking an exchange slot |
| slot_word | input | 16 | Word received in the slot |
| rsp_word | output | 17 | Response returned in the slot (bit 16 status) |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Write enable of the access |
| bus_size | output | 2 | Access size: 0 byte, 1 word, 2 longword |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Write data steered to lanes |
| bus_rdata | input | 32 | Read data from lanes |
| bus_ack | input | 1 | Access completed |
| bus_berr | input | 1 | Access ended with bus error |

## Verification
The bench builds the engine with its default 32-bit address width and 8-bit lanes. The upper address half therefore reaches the bus untouched, and every lane offset a byte or word can take is observable on the enables. A bus responder with a programmable latency of three or six cycles keeps accesses pending across several slots. Errors come from a decoded address window, so the not-ready phase, the dropped words and the bus-error path are all reached from the ports.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

   localparam int WORD_W  = 16;
   localparam int RSP_W   = WORD_W + 1;
   localparam int OP_LSB  = 12;
   localparam int OP_W    = 4;

   localparam logic [OP_W-1:0] OPC_READ  = 4'h1;
   localparam logic [OP_W-1:0] OPC_WRITE = 4'h2;
   localparam logic [OP_W-1:0] OPC_DUMP  = 4'h3;

   localparam logic [RSP_W-1:0] RSP_NOT_READY = 17'h1_0000;
   localparam logic [RSP_W-1:0] RSP_DONE      = 17'h0_FFFF;
   localparam logic [RSP_W-1:0] RSP_BUS_ERR   = 17'h1_0001;
   localparam logic [RSP_W-1:0] RSP_ILLEGAL   = 17'h1_FFFF;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR_HI,
      ST_ADDR_LO,
      ST_DATA_HI,
      ST_DATA_LO,
      ST_BUS,
      ST_RD_LO
   } eng_state_e;

   typedef struct packed {
      logic      is_read;
      logic      is_write;
      logic      is_dump;
      logic      bad;
      acc_size_e size;
   } cmd_dec_t;

   function automatic logic [2:0] size_bytes(acc_size_e s);
      case (s)
         SZ_BYTE: return 3'd1;
         SZ_WORD: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
   import dbg_cmd_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  logic              chain_ok,
   output cmd_dec_t          dec
);

   logic [OP_W-1:0] opc;
   acc_size_e       sz;

   assign opc = word[OP_LSB +: OP_W];
   assign sz  = acc_size_e'(word[1:0]);

   always_comb begin
      dec      = '0;
      dec.size = sz;
      case (opc)
         OPC_READ:  dec.is_read  = 1'b1;
         OPC_WRITE: dec.is_write = 1'b1;
         OPC_DUMP:  dec.is_dump  = 1'b1;
         default:   dec.bad      = 1'b1;
      endcase
      if (sz == SZ_BAD) begin
         dec.bad = 1'b1;
      end
      if (dec.is_dump && !chain_ok) begin
         dec.bad = 1'b1;
      end
   end

endmodule

// File: rtl/dbg_lane_steer.sv
module dbg_lane_steer
   import dbg_cmd_pkg::*;
#(
   parameter  int LANES  = 4,
   parameter  int LANE_W = 8,
   localparam int BUS_W  = LANES * LANE_W,
   localparam int OFS_W  = $clog2(LANES)
)(
   input  acc_size_e          size,
   input  logic [OFS_W-1:0]   ofs,
   input  logic [BUS_W-1:0]   wr_val,
   output logic [LANES-1:0]   lane_en,
   output logic [BUS_W-1:0]   wr_lanes,
   input  logic [BUS_W-1:0]   rd_lanes,
   output logic [BUS_W-1:0]   rd_val
);

   if (LANES != 4) begin : g_bad_lanes
      $error("dbg_lane_steer: exactly four lanes are supported");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [OFS_W-1:0] IDX = OFS_W'(i);
      logic              en_l;
      logic [LANE_W-1:0] wr_l;

      always_comb begin
         case (size)
            SZ_LONG: begin
               en_l = 1'b1;
               wr_l = wr_val[i*LANE_W +: LANE_W];
            end
            SZ_WORD: begin
               en_l = (ofs[OFS_W-1] == IDX[OFS_W-1]);
               wr_l = wr_val[(i % 2)*LANE_W +: LANE_W];
            end
            default: begin
               en_l = (ofs == IDX);
               wr_l = wr_val[LANE_W-1:0];
            end
         endcase
      end

      assign lane_en[i]                   = en_l;
      assign wr_lanes[i*LANE_W +: LANE_W] = wr_l;
   end

   logic [BUS_W-1:0] sh_byte;
   logic [BUS_W-1:0] sh_half;

   always_comb begin
      sh_byte = rd_lanes >> (int'(ofs) * LANE_W);
      sh_half = rd_lanes >> (int'(ofs[OFS_W-1]) * 2 * LANE_W);
      case (size)
         SZ_BYTE: rd_val = {{(BUS_W-LANE_W){1'b0}}, sh_byte[LANE_W-1:0]};
         SZ_WORD: rd_val = {{(BUS_W-2*LANE_W){1'b0}}, sh_half[2*LANE_W-1:0]};
         default: rd_val = rd_lanes;
      endcase
   end

endmodule

// File: rtl/dbg_mem_cmd_engine.sv
module dbg_mem_cmd_engine
   import dbg_cmd_pkg::*;
#(
   parameter  int ADDR_W = 32,
   parameter  int LANE_W = 8,
   localparam int BUS_W  = 2 * WORD_W,
   localparam int LANES  = BUS_W / LANE_W,
   localparam int OFS_W  = $clog2(LANES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_valid,
   input  logic [15:0]       slot_word,
   output logic [16:0]       rsp_word,
   output logic              bus_req,
   output logic              bus_we,
   output logic [1:0]        bus_size,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [3:0]        bus_be,
   output logic [31:0]       bus_wdata,
   input  logic [31:0]       bus_rdata,
   input  logic              bus_ack,
   input  logic              bus_berr
);

   if (LANE_W != 8) begin : g_bad_lane_w
      $error("dbg_mem_cmd_engine: byte operands need 8-bit lanes");
   end
   if (ADDR_W < WORD_W + 1 || ADDR_W > BUS_W) begin : g_bad_addr_w
      $error("dbg_mem_cmd_engine: ADDR_W must lie between 17 and 32");
   end

   eng_state_e       state_q;
   logic [RSP_W-1:0] rsp_q;
   logic [BUS_W-1:0] addr_q;
   logic [BUS_W-1:0] wdat_q;
   logic [WORD_W-1:0] rd_lo_q;
   acc_size_e        size_q;
   logic             we_q;
   logic             chain_q;

   cmd_dec_t         dec;
   logic [BUS_W-1:0] rd_val;
   logic             bus_end;

   dbg_cmd_decode u_dec (
      .word     (slot_word),
      .chain_ok (chain_q),
      .dec      (dec)
   );

   dbg_lane_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_steer (
      .size     (size_q),
      .ofs      (addr_q[OFS_W-1:0]),
      .wr_val   (wdat_q),
      .lane_en  (bus_be),
      .wr_lanes (bus_wdata),
      .rd_lanes (bus_rdata),
      .rd_val   (rd_val)
   );

   assign bus_end  = bus_ack | bus_berr;
   assign bus_req  = (state_q == ST_BUS);
   assign bus_we   = we_q;
   assign bus_size = size_q;
   assign bus_addr = addr_q[ADDR_W-1:0];
   assign rsp_word = rsp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rsp_q   <= RSP_NOT_READY;
         addr_q  <= '0;
         wdat_q  <= '0;
         rd_lo_q <= '0;
         size_q  <= SZ_BYTE;
         we_q    <= 1'b0;
         chain_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (slot_valid) begin
                  if (dec.bad) begin
                     rsp_q   <= RSP_ILLEGAL;
                     chain_q <= 1'b0;
                  end else begin
                     rsp_q  <= RSP_NOT_READY;
                     size_q <= dec.size;
                     if (dec.is_dump) begin
                        addr_q  <= addr_q + BUS_W'(size_bytes(dec.size));
                        we_q    <= 1'b0;
                        state_q <= ST_BUS;
                     end else begin
                        we_q    <= dec.is_write;
                        state_q <= ST_ADDR_HI;
                     end
                  end
               end
            end
            ST_ADDR_HI: begin
               if (slot_valid) begin
                  addr_q[BUS_W-1:WORD_W] <= slot_word;
                  state_q                <= ST_ADDR_LO;
               end
            end
            ST_ADDR_LO: begin
               if (slot_valid) begin
                  addr_q[WORD_W-1:0] <= slot_word;
                  if (!we_q) begin
                     state_q <= ST_BUS;
                  end else if (size_q == SZ_LONG) begin
                     state_q <= ST_DATA_HI;
                  end else begin
                     state_q <= ST_DATA_LO;
                  end
               end
            end
            ST_DATA_HI: begin
               if (slot_valid) begin
                  wdat_q[BUS_W-1:WORD_W] <= slot_word;
                  state_q                <= ST_DATA_LO;
               end
            end
            ST_DATA_LO: begin
               if (slot_valid) begin
                  wdat_q[WORD_W-1:0] <= slot_word;
                  state_q            <= ST_BUS;
               end
            end
            ST_BUS: begin
               if (bus_end) begin
                  if (bus_berr) begin
                     rsp_q   <= RSP_BUS_ERR;
                     chain_q <= 1'b0;
                     state_q <= ST_IDLE;
                  end else if (we_q) begin
                     rsp_q   <= RSP_DONE;
                     chain_q <= 1'b0;
                     state_q <= ST_IDLE;
                  end else if (size_q == SZ_LONG) begin
                     rsp_q   <= {1'b0, rd_val[BUS_W-1:WORD_W]};
                     rd_lo_q <= rd_val[WORD_W-1:0];
                     chain_q <= 1'b1;
                     state_q <= ST_RD_LO;
                  end else begin
                     rsp_q   <= {1'b0, rd_val[WORD_W-1:0]};
                     chain_q <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_RD_LO: begin
               if (slot_valid) begin
                  rsp_q   <= {1'b0, rd_lo_q};
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && !bus_berr) |=>
         (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size)
          && $stable(bus_be) && $stable(bus_wdata)));

   assert_req_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && (bus_ack || bus_berr)) |=> !bus_req);

   assert_done_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack && !bus_berr && bus_we) |=> (rsp_word == RSP_DONE));

   assert_berr_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_berr) |=> (rsp_word == RSP_BUS_ERR));

   assert_pending_nr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && !bus_berr) |=> (rsp_word == RSP_NOT_READY));

   assert_byte_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_size == 2'd0) |-> ($countones(bus_be) == 1));

   assert_long_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_size == 2'd2) |-> (bus_be == 4'hF));

endmodule

// File: tb/dbg_mem_cmd_engine_tb_top.sv
module dbg_mem_cmd_engine_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [16:0] NR   = 17'h1_0000;
   localparam logic [16:0] DONE = 17'h0_FFFF;
   localparam logic [16:0] BERR = 17'h1_0001;
   localparam logic [16:0] ILL  = 17'h1_FFFF;
   localparam logic [15:0] COLLECT = 16'hF000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slot_valid = 1'b0;
   logic [15:0] slot_word = '0;
   logic [16:0] rsp_word;
   logic        bus_req, bus_we;
   logic [1:0]  bus_size;
   logic [31:0] bus_addr;
   logic [3:0]  bus_be;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic        bus_ack = 1'b0;
   logic        bus_berr = 1'b0;

   logic [7:0]  mem [0:255];
   int          lat = 3;
   int          req_count = 0;
   logic [31:0] cap_addr, cap_wdata;
   logic [3:0]  cap_be;
   logic        cap_we;
   logic [1:0]  cap_size;
   logic [16:0] exp_prev = NR;
   int          n_chk = 0;
   int          n_fail = 0;
   logic        done = 1'b0;

   dbg_mem_cmd_engine dut_i (
      .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_word(slot_word),
      .rsp_word(rsp_word), .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_berr(bus_berr)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // bus responder: counts latency on negative edges, ends with ack or error
   initial begin
      int          cnt;
      logic [31:0] h_addr, h_wdata;
      logic [3:0]  h_be;
      logic        h_we;
      logic [7:0]  base;
      cnt = 0;
      forever begin
         @(negedge clk);
         if (bus_req && !bus_ack && !bus_berr) begin
            if (cnt == 0) begin
               req_count++;
               h_addr = bus_addr; h_wdata = bus_wdata; h_be = bus_be; h_we = bus_we;
            end else begin
               chk("R11 request stable", {bus_addr[31:1] ^ h_addr[31:1], bus_we ^ h_we},
                   32'h0);
               chk("R11 lanes stable", {bus_be ^ h_be, 28'h0} | (bus_wdata ^ h_wdata), 32'h0);
            end
            cnt++;
            if (cnt >= lat) begin
               cnt = 0;
               cap_addr = bus_addr; cap_wdata = bus_wdata; cap_be = bus_be;
               cap_we = bus_we; cap_size = bus_size;
               base = {bus_addr[7:2], 2'b00};
               if (bus_addr[15:12] == 4'hE) begin
                  bus_berr = 1'b1;
               end else begin
                  bus_ack = 1'b1;
                  if (bus_we) begin
                     for (int k = 0; k < 4; k++)
                        if (bus_be[k]) mem[base + 8'(k)] = bus_wdata[k*8 +: 8];
                  end else begin
                     bus_rdata = {mem[base + 8'd3], mem[base + 8'd2],
                                  mem[base + 8'd1], mem[base]};
                  end
               end
            end
         end else begin
            bus_ack = 1'b0;
            bus_berr = 1'b0;
         end
      end
   end

   function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [31:0] a);
      logic [7:0] b;
      b = a[7:0];
      case (sz)
         2'd0:    return {24'h0, mem[b]};
         2'd1:    return {16'h0, mem[{b[7:1], 1'b1}], mem[{b[7:1], 1'b0}]};
         default: return {mem[{b[7:2], 2'd3}], mem[{b[7:2], 2'd2}],
                          mem[{b[7:2], 2'd1}], mem[{b[7:2], 2'd0}]};
      endcase
   endfunction

   function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [31:0] a);
      case (sz)
         2'd0:    return 4'b0001 << a[1:0];
         2'd1:    return a[1] ? 4'b1100 : 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic logic [2:0] nbytes(input logic [1:0] sz);
      return (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
   endfunction

   task automatic slot(input logic [15:0] w, output logic [16:0] r);
      @(negedge clk);
      r = rsp_word;
      slot_word = w;
      slot_valid = 1'b1;
      @(negedge clk);
      slot_valid = 1'b0;
   endtask

   task automatic slot_chk(input logic [15:0] w, input logic [16:0] exp, input string tag);
      logic [16:0] r;
      slot(w, r);
      chk(tag, {15'h0, r}, {15'h0, exp});
   endtask

   task automatic send_addr(input logic [31:0] a);
      slot_chk(a[31:16], NR, "R7 addr hi slot");
      slot_chk(a[15:0], NR, "R7 addr lo slot");
   endtask

   task automatic wait_done();
      slot_chk(16'h0000, NR, "R7 pending slot, word dropped");
      repeat (3 * lat + 6) @(negedge clk);
   endtask

   task automatic collect(input logic [1:0] sz, input logic [31:0] v,
                          input logic [15:0] next_w, input string tag);
      if (sz == 2'd2) begin
         slot_chk(16'h0000, {1'b0, v[31:16]}, {tag, " long hi (R8)"});
         slot_chk(next_w, {1'b0, v[15:0]}, {tag, " long lo (R8)"});
      end else begin
         slot_chk(next_w, {1'b0, v[15:0]}, tag);
      end
   endtask

   task automatic t_reset();
      chk("R1 reset response", {15'h0, rsp_word}, {15'h0, NR});
      chk("R1 reset no request", {31'h0, bus_req}, 32'h0);
   endtask

   task automatic t_illegal();
      int rc;
      rc = req_count;
      slot_chk(16'h7001, exp_prev, "R2 response before bad opcode");
      slot_chk(16'h1003, ILL, "R2 bad opcode code");
      slot_chk(16'h3000, ILL, "R2 bad size code");
      slot_chk(COLLECT, ILL, "R10 dump without read");
      chk("R2 no bus access", req_count, rc);
      exp_prev = ILL;
   endtask

   task automatic t_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
      logic [31:0] lanes, mask;
      slot_chk({4'h2, 10'h0, sz}, exp_prev, "R2 response before write");
      send_addr(a);
      if (sz == 2'd2) begin
         slot_chk(d[31:16], NR, "R7 data hi slot");
         slot_chk(d[15:0], NR, "R7 data lo slot");
      end else if (sz == 2'd1) begin
         slot_chk(d[15:0], NR, "R7 data slot");
      end else begin
         slot_chk({8'h5A, d[7:0]}, NR, "R7 data slot");
      end
      wait_done();
      chk("R3 write address", cap_addr, a);
      chk("R4 write enable", {31'h0, cap_we}, 32'h1);
      chk("R4 write enables", {28'h0, cap_be}, {28'h0, exp_be(sz, a)});
      case (sz)
         2'd0:    lanes = {4{d[7:0]}};
         2'd1:    lanes = {2{d[15:0]}};
         default: lanes = d;
      endcase
      mask = {{8{cap_be[3]}}, {8{cap_be[2]}}, {8{cap_be[1]}}, {8{cap_be[0]}}};
      chk("R4 write lanes", cap_wdata & mask, lanes & mask);
      chk("R4 stored value", exp_read(sz, a), d & ((sz == 2'd0) ? 32'hFF :
                                                    (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF));
      slot_chk(COLLECT, DONE, "R5 write complete");
      exp_prev = ILL;
   endtask

   task automatic t_read(input logic [1:0] sz, input logic [31:0] a);
      slot_chk({4'h1, 10'h0, sz}, exp_prev, "R2 response before read");
      send_addr(a);
      wait_done();
      chk("R3 read address", cap_addr, a);
      chk("R8 read no write", {31'h0, cap_we}, 32'h0);
      chk("R8 read enables", {28'h0, cap_be}, {28'h0, exp_be(sz, a)});
      collect(sz, exp_read(sz, a), COLLECT, "R8 read data");
      exp_prev = ILL;
   endtask

   task automatic t_dump(input logic [1:0] sz, input logic [31:0] a, input int n);
      logic [31:0] cur;
      slot_chk({4'h1, 10'h0, sz}, exp_prev, "R2 response before read");
      send_addr(a);
      wait_done();
      cur = a;
      for (int i = 0; i < n; i++) begin
         collect(sz, exp_read(sz, cur), {4'h3, 10'h0, sz}, "R9 R12 item then dump");
         cur = cur + 32'(nbytes(sz));
         wait_done();
         chk("R9 dump address step", cap_addr, cur);
         chk("R9 dump size", {30'h0, cap_size}, {30'h0, sz});
      end
      collect(sz, exp_read(sz, cur), COLLECT, "R9 last dump item");
      exp_prev = ILL;
   endtask

   task automatic t_berr();
      int rc;
      slot_chk(16'h1001, exp_prev, "R2 response before read");
      send_addr(32'h0000_0020);
      wait_done();
      collect(2'd1, exp_read(2'd1, 32'h20), 16'h1001, "R12 result with next read");
      send_addr(32'h0000_E020);
      wait_done();
      slot_chk(16'h3001, BERR, "R6 read bus error");
      rc = req_count;
      slot_chk(COLLECT, ILL, "R6 R10 dump after error refused");
      chk("R10 no access after refused dump", req_count, rc);
      slot_chk(16'h2001, ILL, "R2 response before write");
      send_addr(32'h0000_E010);
      slot_chk(16'h1234, NR, "R7 data slot");
      wait_done();
      slot_chk(COLLECT, BERR, "R6 write bus error");
      exp_prev = ILL;
   endtask

   task automatic t_chain_break();
      int rc;
      slot_chk(16'h1000, exp_prev, "R2 response before read");
      send_addr(32'h0000_0050);
      wait_done();
      collect(2'd0, exp_read(2'd0, 32'h50), 16'h2000, "R12 result with write");
      send_addr(32'h0000_0060);
      slot_chk(16'h0077, NR, "R7 data slot");
      wait_done();
      slot_chk(16'h3000, DONE, "R5 write done, dump follows");
      rc = req_count;
      slot_chk(COLLECT, ILL, "R10 dump after write refused");
      chk("R10 no access", req_count, rc);
      exp_prev = ILL;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_illegal();
      t_write(2'd0, 32'h0000_0011, 32'h0000_00A5);
      t_read(2'd0, 32'h0000_0011);
      t_write(2'd1, 32'h0000_0022, 32'h0000_BEEF);
      t_write(2'd2, 32'h1234_0080, 32'h1234_5678);
      t_read(2'd1, 32'h0000_0022);
      t_read(2'd2, 32'h0000_0080);
      t_read(2'd0, 32'h0000_0083);
      lat = 6;
      t_dump(2'd0, 32'h0000_0005, 3);
      t_dump(2'd1, 32'h0000_0030, 2);
      t_dump(2'd2, 32'h0000_003C, 2);
      t_berr();
      lat = 3;
      t_chain_break();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule